// File: doc/BRIEF.md
# Watchdog Timer with Prewarning Window

This block supervises software through a 16-bit up-counter that advances on prescaled ticks of the peripheral clock. The prescaler divides the clock by 2 or by 128. Software must issue a refresh strobe often enough to stop the counter from wrapping. A refresh reloads the counter: the 8-bit reload value goes into the upper byte and the lower byte is cleared.

When the counter wraps without a refresh, the block does not reset the system at once. It leaves normal operation and sets a sticky non-maskable interrupt flag. It then counts down a fixed prewarning window of 0x3000 prescaled ticks, which is 0x30 steps of the counter's upper byte. Interrupt code can use this window to record its state. If the window runs out, the block issues a one-cycle reset request to the reset generator. It then waits for that reset to arrive.

The controller has four states in a 2-bit register: DISABLED=0, NORMAL=1, PREWARNING=2 and RESET_REQ=3. The transitions are:

- enable: DISABLED to NORMAL, when the enable input is high.
- disable: NORMAL to DISABLED, when the enable input is low.
- overflow: NORMAL to PREWARNING.
- expire: PREWARNING to RESET_REQ.
- system reset: any state to DISABLED. This is the only way out of PREWARNING and RESET_REQ.

Top module: `wdt_prewarn_top`

## Requirements
- R1: After reset the state is DISABLED and both `nmi_flag` and `rst_req` are low. While `wd_en` stays low, neither output ever rises.
- R2: Raising `wd_en` in DISABLED enters NORMAL. The counter starts at {`reload_hi`, 8'h00}, so the overflow occurs on prescaled tick number 65536 - 256*`reload_hi`.
- R3: With `presc_sel`=0 a tick occurs every 2 clocks, and with `presc_sel`=1 every 128 clocks. So the overflow takes effect at clock edge D*(65536 - 256*`reload_hi`) after the enable edge (edge 0), where D is the divisor.
- R4: A `refresh` strobe in NORMAL reloads the counter from `reload_hi`, with the lower byte cleared, and restarts the prescaler. The next overflow lands D*(65536 - 256*`reload_hi`) edges after the refresh edge.
- R5: On the overflow edge the block enters PREWARNING, and `nmi_flag` is high right after that edge.
- R6: `nmi_flag` stays high until a clock edge that samples `nmi_clr`=1 (write-one-to-clear). It stays high through the reset request.
- R7: The prewarning window lasts 0x3000 ticks. `rst_req` is high for exactly one clock, right after edge D*0x3000 past the overflow edge, and the state then holds in RESET_REQ.
- R8: In PREWARNING and RESET_REQ, `refresh` and `wd_en` have no effect. No second interrupt and no second reset request follow without a system reset.
- R9: While `wd_suspend` is high in NORMAL or PREWARNING, the prescaler and the counter hold. Each suspended clock delays the overflow or the expiry by exactly one clock.
- R10: Dropping `wd_en` in NORMAL returns to DISABLED, and no overflow follows. Enabling again starts a fresh count from `reload_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low system reset |
| wd_en | input | 1 | Watchdog enable |
| wd_suspend | input | 1 | Freezes prescaler and counter while high |
| presc_sel | input | 1 | 0: divide by 2, 1: divide by 128 |
| reload_hi | input | 8 | Reload value for the counter's upper byte |
| refresh | input | 1 | Service strobe, one clock wide |
| nmi_clr | input | 1 | Write-one-to-clear for the interrupt flag |
| nmi_flag | output | 1 | Sticky non-maskable interrupt request |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench pins the overflow and the reset request to exact clock edges, one edge before and on the edge itself. A design that miscounted the prescaler, put the reload in the lower byte, or took the window as 0x30 ticks instead of 0x3000 would miss these edges. It strobes refresh and toggles enable inside the prewarning window. A design that went back to NORMAL there would shift the reset request or raise a second interrupt. Suspend is held for known stretches in both counting states; an off-by-one in the freeze would move the event by a clock. Disable followed by re-enable must restart from the reload value and not resume a stale count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        ST_DISABLED   = 2'd0,
        ST_NORMAL     = 2'd1,
        ST_PREWARNING = 2'd2,
        ST_RESET_REQ  = 2'd3
    } wd_state_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int DIV_FAST = 2,
    parameter int DIV_SLOW = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic sel,
    output logic tick
);
    localparam int PW = (DIV_SLOW > 2) ? $clog2(DIV_SLOW) : 1;

    logic [PW-1:0] pcnt;
    logic [PW-1:0] limit;

    assign limit = sel ? PW'(DIV_SLOW - 1) : PW'(DIV_FAST - 1);
    assign tick  = run && (pcnt >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (restart) begin
            pcnt <= '0;
        end else if (run) begin
            pcnt <= tick ? '0 : pcnt + 1'b1;
        end
    end

    // R9: a stopped prescaler keeps its phase
    assert_presc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(pcnt));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int                 CW            = 16,
    parameter int                 RW            = 8,
    parameter logic [CW-1:0]      PREWARN_TICKS = 16'h3000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  wd_state_t     state,
    input  logic          tick,
    input  logic          refresh,
    input  logic [RW-1:0] reload,
    output logic          overflow,
    output logic          expire
);
    localparam int LW = CW - RW;

    logic [CW-1:0] cnt;
    logic [CW-1:0] load_val;

    assign load_val = {reload, {LW{1'b0}}};
    assign overflow = (state == ST_NORMAL) && !refresh && tick && (&cnt);
    assign expire   = (state == ST_PREWARNING) && tick && (cnt == CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            unique case (state)
                ST_DISABLED: cnt <= load_val;
                ST_NORMAL: begin
                    if (refresh)       cnt <= load_val;
                    else if (overflow) cnt <= PREWARN_TICKS;
                    else if (tick)     cnt <= cnt + 1'b1;
                end
                ST_PREWARNING: begin
                    if (tick && cnt != '0) cnt <= cnt - 1'b1;
                end
                ST_RESET_REQ: cnt <= cnt;
            endcase
        end
    end

    // R4: refresh in NORMAL lands the reload image in the counter
    assert_refresh_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORMAL && refresh) |=> (cnt == $past(load_val)));

    // R7: the window starts at its full length
    assert_window_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> (cnt == PREWARN_TICKS));
endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      overflow,
    input  logic      expire,
    input  logic      nmi_clr,
    output wd_state_t state,
    output logic      nmi_flag,
    output logic      rst_req
);
    wd_state_t state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_DISABLED:   if (en) state_nx = ST_NORMAL;
            ST_NORMAL: begin
                if (!en)           state_nx = ST_DISABLED;
                else if (overflow) state_nx = ST_PREWARNING;
            end
            ST_PREWARNING: if (expire) state_nx = ST_RESET_REQ;
            ST_RESET_REQ:  state_nx = ST_RESET_REQ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_DISABLED;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_flag <= 1'b0;
            rst_req  <= 1'b0;
        end else begin
            if (state == ST_NORMAL && state_nx == ST_PREWARNING) nmi_flag <= 1'b1;
            else if (nmi_clr)                                     nmi_flag <= 1'b0;
            rst_req <= (state == ST_PREWARNING) && (state_nx == ST_RESET_REQ);
        end
    end

    // R7: reset request never lasts beyond one clock
    assert_rstreq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R6: flag holds until cleared
    assert_nmi_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_flag && !nmi_clr) |=> nmi_flag);

    // R8: prewarning only moves forward
    assert_prewarn_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PREWARNING) |=> (state == ST_PREWARNING || state == ST_RESET_REQ));

    // R5: entering prewarning raises the interrupt
    assert_nmi_on_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PREWARNING && $past(state) == ST_NORMAL) |-> nmi_flag);
endmodule

// File: rtl/wdt_prewarn_top.sv
module wdt_prewarn_top
    import wdt_pkg::*;
#(
    parameter int            CW            = 16,
    parameter int            RW            = 8,
    parameter int            DIV_FAST      = 2,
    parameter int            DIV_SLOW      = 128,
    parameter logic [CW-1:0] PREWARN_TICKS = 16'h3000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wd_en,
    input  logic          wd_suspend,
    input  logic          presc_sel,
    input  logic [RW-1:0] reload_hi,
    input  logic          refresh,
    input  logic          nmi_clr,
    output logic          nmi_flag,
    output logic          rst_req
);
    wd_state_t state;
    logic      tick;
    logic      overflow;
    logic      expire;
    logic      run;
    logic      restart;

    assign run     = (state == ST_NORMAL || state == ST_PREWARNING) && !wd_suspend;
    assign restart = (state == ST_DISABLED) || (state == ST_NORMAL && refresh);

    wdt_prescaler #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .sel     (presc_sel),
        .tick    (tick)
    );

    wdt_counter #(.CW(CW), .RW(RW), .PREWARN_TICKS(PREWARN_TICKS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .tick     (tick),
        .refresh  (refresh),
        .reload   (reload_hi),
        .overflow (overflow),
        .expire   (expire)
    );

    wdt_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (wd_en),
        .overflow (overflow),
        .expire   (expire),
        .nmi_clr  (nmi_clr),
        .state    (state),
        .nmi_flag (nmi_flag),
        .rst_req  (rst_req)
    );

    // R10: a disabled watchdog cannot overflow
    assert_no_overflow_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DISABLED) |-> !overflow);
endmodule

// File: tb/tb_wdt_prewarn_top.sv
`timescale 1ns/1ps
module tb_wdt_prewarn_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wd_en = 1'b0;
    logic       wd_suspend = 1'b0;
    logic       presc_sel = 1'b0;
    logic [7:0] reload_hi = 8'hFF;
    logic       refresh = 1'b0;
    logic       nmi_clr = 1'b0;
    logic       nmi_flag;
    logic       rst_req;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdt_prewarn_top dut (
        .clk(clk), .rst_n(rst_n), .wd_en(wd_en), .wd_suspend(wd_suspend),
        .presc_sel(presc_sel), .reload_hi(reload_hi), .refresh(refresh),
        .nmi_clr(nmi_clr), .nmi_flag(nmi_flag), .rst_req(rst_req)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s at cycle %0d: actual=%b expected=%b", req, cyc, act, exp);
        end
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; wd_en = 0; wd_suspend = 0; presc_sel = 0;
        reload_hi = 8'hFF; refresh = 0; nmi_clr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    // enable at a negedge; returns cyc value so that edge k is base+1+k
    task automatic start(input logic sel, input logic [7:0] rl, output int base);
        @(negedge clk);
        presc_sel = sel; reload_hi = rl; wd_en = 1;
        base = cyc;
    endtask

    task automatic pulse_refresh();
        @(negedge clk); refresh = 1;
        @(negedge clk); refresh = 0;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        check("R1 nmi after reset", nmi_flag, 1'b0);
        check("R1 rst_req after reset", rst_req, 1'b0);
        wait_to(cyc + 1500);
        check("R1 nmi idle while disabled", nmi_flag, 1'b0);
    endtask

    task automatic t_full_sequence();
        int b;
        do_reset();
        start(1'b0, 8'hFF, b);
        wait_to(b + 1 + 511);
        check("R5 nmi before overflow edge", nmi_flag, 1'b0);
        wait_to(b + 1 + 512);
        check("R5 R3 nmi on overflow edge div2", nmi_flag, 1'b1);
        wait_to(b + 1 + 1000);
        pulse_refresh();
        @(negedge clk); wd_en = 0;
        wait_to(b + 1 + 1200);
        @(negedge clk); wd_en = 1;
        pulse_refresh();
        wait_to(b + 1 + 25087);
        check("R7 R8 rst_req one edge early", rst_req, 1'b0);
        wait_to(b + 1 + 25088);
        check("R7 R8 rst_req on expiry edge", rst_req, 1'b1);
        wait_to(b + 1 + 25089);
        check("R7 rst_req single cycle", rst_req, 1'b0);
        check("R6 nmi sticky through reset request", nmi_flag, 1'b1);
        @(negedge clk); nmi_clr = 1;
        @(negedge clk); nmi_clr = 0;
        check("R6 nmi cleared by write-one", nmi_flag, 1'b0);
        pulse_refresh();
        wait_to(cyc + 3000);
        check("R8 no new nmi in reset_req", nmi_flag, 1'b0);
        check("R8 no new rst_req in reset_req", rst_req, 1'b0);
    endtask

    task automatic t_refresh_normal();
        int b;
        int r;
        do_reset();
        start(1'b0, 8'hF0, b);
        wait_to(b + 1 + 6001);
        @(negedge clk); refresh = 1; r = cyc;
        @(negedge clk); refresh = 0;
        wait_to(r + 1 + 8191);
        check("R4 R2 nmi before post-refresh overflow", nmi_flag, 1'b0);
        wait_to(r + 1 + 8192);
        check("R4 R2 nmi on post-refresh overflow", nmi_flag, 1'b1);
    endtask

    task automatic t_div128();
        int b;
        do_reset();
        start(1'b1, 8'hFF, b);
        wait_to(b + 1 + 32767);
        check("R3 div128 nmi one edge early", nmi_flag, 1'b0);
        wait_to(b + 1 + 32768);
        check("R3 div128 nmi on overflow", nmi_flag, 1'b1);
    endtask

    task automatic t_suspend();
        int b;
        do_reset();
        start(1'b0, 8'hFF, b);
        wait_to(b + 1 + 100);
        @(negedge clk); wd_suspend = 1;
        repeat (37) @(negedge clk);
        wd_suspend = 0;
        wait_to(b + 1 + 548);
        check("R9 suspend delays overflow (early)", nmi_flag, 1'b0);
        wait_to(b + 1 + 549);
        check("R9 suspend delays overflow", nmi_flag, 1'b1);
        wait_to(b + 1 + 2000);
        @(negedge clk); wd_suspend = 1;
        repeat (50) @(negedge clk);
        wd_suspend = 0;
        wait_to(b + 1 + 25088 + 87 - 1);
        check("R9 suspend delays expiry (early)", rst_req, 1'b0);
        wait_to(b + 1 + 25088 + 87);
        check("R9 suspend delays expiry", rst_req, 1'b1);
    endtask

    task automatic t_disable();
        int b;
        int b2;
        do_reset();
        start(1'b0, 8'hFF, b);
        wait_to(b + 1 + 300);
        @(negedge clk); wd_en = 0;
        wait_to(b + 1 + 2000);
        check("R10 no overflow after disable", nmi_flag, 1'b0);
        start(1'b0, 8'hFF, b2);
        wait_to(b2 + 1 + 511);
        check("R10 re-enable restarts count (early)", nmi_flag, 1'b0);
        wait_to(b2 + 1 + 512);
        check("R10 re-enable restarts count", nmi_flag, 1'b1);
    endtask

    initial begin
        t_reset();
        t_full_sequence();
        t_refresh_normal();
        t_div128();
        t_suspend();
        t_disable();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #1520000;
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule